// File: doc/BRIEF.md
# Edge-Selectable Latched Interrupt Controller

This block gathers the status flags of a multi-channel serial FIFO card, plus the interrupt lines of its serial controllers, into one interrupt request for the host. Each of the `NSRC` source inputs owns the bit of the same index in every register. Most sources are FIFO flags. Each of these is edge-triggered, and software chooses per bit whether the rising or the falling transition of the flag sets a sticky pending bit. The sources marked in the `LEVEL_MASK` parameter are level-sensitive. Their status bit simply reflects the live condition.

Software reaches three registers over a small strobe-based bus. The enable register gates which sources may raise the request. The status register shows pending bits, and a write of 1 to a bit clears it. The polarity register picks the triggering edge. Source inputs are asynchronous and pass through a two-flop synchronizer. Edges are found by comparing the synchronized value with a registered copy of it. An edge on an input therefore latches on the third rising clock edge after the input changes.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Source n maps to bit n of every register. The enable register is at offset 0x60, the status register at 0x64 and the polarity register at 0x68. A read of any other offset returns zero.
- R2: An enabled edge source whose polarity bit is 1 latches its status bit when the synchronized input goes from 0 to 1. The bit becomes visible on the third rising clock edge after the input change.
- R3: An enabled edge source whose polarity bit is 0 latches on a 1-to-0 transition. A 0-to-1 transition of that source latches nothing.
- R4: An edge that arrives while the source's enable bit is 0 latches nothing, and enabling the source later does not recover it.
- R5: Writing 1 to a status bit clears it. Bits written with 0 keep their value, and a 1 written to a bit that is not pending has no effect.
- R6: Writing 0 to an enable bit clears that source's latched status in the same cycle.
- R7: If a qualifying edge and a write-1 clear of the same bit take effect on the same clock edge, the bit stays set.
- R8: A level source's status bit reads the synchronized input regardless of its enable bit, and write-1 clears do not change it. The polarity bits of level sources read as 0.
- R9: `irq` is high exactly when some enabled edge source is pending or some enabled level source is asserted.
- R10: After reset the enable and status registers read 0, the polarity register reads 1 on every edge source, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Raw source flags, one per bit, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; read data is combinational |
| addr | input | AW | Register byte offset |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data, zero when `rd_en` is low |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
A wrong pending bit is seen in two places. It changes the status readback in the cycle after the offending clock edge. It also changes `irq` in that same cycle whenever the bit is enabled. Because of this, the bench samples status and the request together, a fixed number of cycles after each input change. A corrupted synchronizer or edge-history stage behaves differently. It moves the latch cycle or adds a spurious latch, so the bench also checks the exact cycle on which a latch occurs and checks the case where a clear and an edge coincide. A polarity register that does not track its writes shows up as an edge of the wrong direction latching.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] EN_OFS = 8'h60,
  parameter logic [AW-1:0] ST_OFS = 8'h64,
  parameter logic [AW-1:0] POL_OFS = 8'h68,
  parameter logic [NSRC-1:0] LEVEL_MASK = 32'h0000_8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq
);
  localparam logic [NSRC-1:0] EDGE_MASK = ~LEVEL_MASK;

  logic [NSRC-1:0] sync1, sync2, prev;
  logic [NSRC-1:0] en_q, stat_q, pol_q;
  logic [NSRC-1:0] en_d, stat_d, clr, hit, lvl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign hit = EDGE_MASK & ((pol_q & sync2 & ~prev) | (~pol_q & ~sync2 & prev));
  assign lvl = LEVEL_MASK & sync2;

  assign en_d   = (wr_en && addr == EN_OFS) ? wdata : en_q;
  assign clr    = (wr_en && addr == ST_OFS) ? wdata : '0;
  assign stat_d = EDGE_MASK & en_d & ((en_q & hit) | (stat_q & ~clr));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      pol_q  <= EDGE_MASK;
    end else begin
      en_q   <= en_d;
      stat_q <= stat_d;
      if (wr_en && addr == POL_OFS) pol_q <= wdata & EDGE_MASK;
    end

  always_comb begin
    rdata = '0;
    if (rd_en)
      case (addr)
        EN_OFS:  rdata = en_q;
        ST_OFS:  rdata = stat_q | lvl;
        POL_OFS: rdata = pol_q;
        default: rdata = '0;
      endcase
  end

  assign irq = (|stat_q) | (|(lvl & en_q));

  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ST_OFS) |=> ((stat_q & $past(wdata) & ~$past(hit & en_q)) == '0));

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == EN_OFS) |=> ((stat_q & ~$past(wdata)) == '0));

  a_r4_latch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  a_r7_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == ST_OFS || addr == EN_OFS)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  a_r8_level_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & LEVEL_MASK) == '0));
endmodule

// File: tb/edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module edge_irq_ctrl_bench;
  localparam logic [7:0] EN = 8'h60, ST = 8'h64, PL = 8'h68;
  localparam int LV = 15;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [31:0] src_i = '0, wdata = '0, rdata;
  logic [7:0] addr = '0;
  int runs = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  edge_irq_ctrl u_edge_irq_ctrl (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1; #1 d = rdata; rd_en = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(EN, v); check("R10 enable", v, 0);
    rd(ST, v); check("R10 status", v, 0);
    rd(PL, v); check("R10 polarity", v, 32'hFFFF_7FFF);
    check("R10 irq", irq, 0);
    rd(8'h6C, v); check("R1 unused offset", v, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(EN, 32'h1);
    src_i[0] = 1;
    tick(2); rd(ST, v); check("R2 not yet latched", v, 0);
    tick(1); rd(ST, v); check("R2 rising latch", v, 32'h1);
    check("R9 irq on pending", irq, 1);
    wr(ST, 32'h1); rd(ST, v); check("R5 clear", v, 0);
    check("R9 irq dropped", irq, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    wr(PL, 32'hFFFF_FFFD);
    rd(PL, v); check("R8 polarity of level bit", v, 32'hFFFF_7FFD);
    wr(EN, 32'h3);
    src_i[1] = 1; tick(4); rd(ST, v); check("R3 rise ignored", v, 0);
    src_i[1] = 0; tick(4); rd(ST, v); check("R3 falling latch", v, 32'h2);
  endtask

  task automatic t_partial_clear();
    logic [31:0] v;
    src_i[0] = 0; tick(3);
    src_i[0] = 1; tick(4);
    rd(ST, v); check("R1 two pending", v, 32'h3);
    wr(ST, 32'h0000_0011); rd(ST, v); check("R5 partial clear", v, 32'h2);
    wr(EN, 32'h1); rd(ST, v); check("R6 disable clears", v, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    wr(EN, 32'h0);
    src_i[2] = 1; tick(4);
    wr(EN, 32'h4); rd(ST, v); check("R4 disabled edge lost", v, 0);
    check("R4 irq", irq, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(EN, 32'h0);
    src_i[LV] = 1; tick(3);
    rd(ST, v); check("R8 live while disabled", v, 32'h8000);
    check("R9 disabled level", irq, 0);
    wr(EN, 32'h8000); check("R9 enabled level", irq, 1);
    wr(ST, 32'h8000); rd(ST, v); check("R8 clear no effect", v, 32'h8000);
    src_i[LV] = 0; tick(3); rd(ST, v); check("R8 level falls", v, 0);
    check("R9 level gone", irq, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(EN, 32'h10); wr(PL, 32'hFFFF_FFFF);
    src_i[4] = 1; tick(4);
    src_i[4] = 0; tick(4);
    rd(ST, v); check("R2 setup", v, 32'h10);
    src_i[4] = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(ST, 32'h10);
    rd(ST, v); check("R7 edge beats clear", v, 32'h10);
    wr(ST, 32'h10); rd(ST, v); check("R5 later clear", v, 0);
  endtask

  initial begin
    tick(2); rst_n = 1; tick(1);
    t_reset(); t_rise(); t_fall(); t_partial_clear();
    t_disabled(); t_level(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); runs++; fails++; $display("FAIL watchdog"); end
    join_any
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule